// File: doc/BRIEF.md
# Five-stage pipeline stall interlock

This unit decides, once per cycle, whether the instruction sitting in the decode stage of an in-order five-stage integer pipeline may proceed. The pipeline has no bypass network, so a consumer can only take an operand from the register file. That file is written in the first half of a cycle and read in the second half. A producer therefore blocks its consumers while it sits in execute or memory, and stops blocking once it reaches write-back. Conditional branches test a register against zero during decode and redirect fetch there when the test succeeds.

The unit receives the decoded fields of the decode-stage instruction: a valid bit, two source register addresses with use flags, a destination address with a write enable, a branch flag and the outcome of the zero test. It keeps its own record of the destinations that have moved on into execute and memory. It drives `stall_o`, which holds the PC and the fetch/decode register, and `bubble_o`, which loads a no-op with its write enable cleared into the execute stage. It also drives `flush_o`, which discards the instruction fetched behind a taken branch. Stores present both their base register and their data register as sources.

Top module: `hz_interlock`

## Requirements
- R1: After reset no earlier producer is tracked, so the first decode-stage instruction never stalls, whatever registers it reads.
- R2: A valid decode-stage instruction stalls when a used source equals the nonzero destination of the write-enabled instruction accepted one cycle earlier. Loads and ALU operations are treated the same.
- R3: A valid decode-stage instruction also stalls when a used source equals the destination of the write-enabled instruction accepted two cycles earlier. A consumer directly behind its producer therefore stalls exactly two cycles.
- R4: A producer accepted three or more cycles earlier is in write-back or beyond and never causes a stall.
- R5: Register address 0 never causes a stall, either as a source or as a destination.
- R6: Both source fields take part in the comparison. A store stalls on its data register (second source field) as well as on its base register (first source field).
- R7: `bubble_o` is high in exactly the cycles where `stall_o` is high. The bubble carries no write enable, so it never makes a later instruction stall.
- R8: A valid branch whose zero test succeeds and that does not stall raises `flush_o` for that cycle only.
- R9: Stall has priority over flush: a branch still waiting for its operand never raises `flush_o`.
- R10: An invalid decode slot, or a source whose use flag is low, never causes a stall or a flush.
- R11: On the eight-instruction load/add/branch/store test program the branch is taken to the final store or not taken. Not taken, the program occupies decode for 16 cycles with 8 bubbles. Taken, it needs 10 cycles with 4 bubbles and one flushed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| id_src_addr_i | input | NUM_SRC*REG_AW | Source register addresses; field k at bits [k*REG_AW +: REG_AW] |
| id_src_used_i | input | NUM_SRC | Per-source use flag |
| id_dst_addr_i | input | REG_AW | Destination register address |
| id_dst_we_i | input | 1 | Instruction writes its destination |
| id_is_branch_i | input | 1 | Instruction is a conditional zero-test branch |
| id_br_cond_i | input | 1 | Zero test succeeds (branch would be taken) |
| stall_o | output | 1 | Hold PC and fetch/decode register |
| bubble_o | output | 1 | Load a write-disabled no-op into execute |
| flush_o | output | 1 | Discard the fetch/decode register; redirect PC |

## Verification
The tracked destinations for execute and memory are the only state. A corrupted entry shows at the ports in the very cycle a consumer of that register reaches decode: a missed stall, or a spurious stall that delays the PC. A stale entry that is not aged out shows as a third stall cycle, which changes the program's total cycle and bubble counts. A wrong shift between the two entries shows as a consumer stalling one cycle instead of two. The bench compares all three outputs on every cycle against an independent queue model, so any such fault is reported in the cycle it first reaches the outputs.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Decision taken for the decode-stage instruction in the current cycle.
  typedef enum logic [1:0] {
    HZ_RUN      = 2'd0,
    HZ_HOLD     = 2'd1,
    HZ_REDIRECT = 2'd2
  } hz_action_e;

endpackage

// File: rtl/hz_dst_track.sv
// Shift chain of destination records for instructions that left decode.
// Entry 0 is the execute stage, entry DEPTH-1 the last stage still unreadable.
module hz_dst_track #(
  parameter int AW    = 5,
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_wr,
  input  logic [AW-1:0]     in_rd,
  output logic [DEPTH-1:0]  stg_wr,
  output logic [DEPTH*AW-1:0] stg_rd
);

  logic [DEPTH-1:0]    wr_nxt;
  logic [DEPTH*AW-1:0] rd_nxt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb begin
        wr_nxt[0]       = in_wr;
        rd_nxt[0 +: AW] = in_rd;
      end
    end else begin : g_body
      always_comb begin
        wr_nxt[g]            = stg_wr[g-1];
        rd_nxt[g*AW +: AW]   = stg_rd[(g-1)*AW +: AW];
      end
    end

    // Valid bit always advances; the address register is clock-enabled
    // by the incoming valid bit so bubbles do not toggle it.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_wr[g] <= 1'b0;
      end else begin
        stg_wr[g] <= wr_nxt[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_rd[g*AW +: AW] <= '0;
      end else if (wr_nxt[g]) begin
        stg_rd[g*AW +: AW] <= rd_nxt[g*AW +: AW];
      end
    end
  end

endmodule

// File: rtl/hz_src_match.sv
// Compares one decode-stage source against every tracked destination.
module hz_src_match #(
  parameter int AW    = 5,
  parameter int DEPTH = 2
) (
  input  logic                used,
  input  logic [AW-1:0]       addr,
  input  logic [DEPTH-1:0]    stg_wr,
  input  logic [DEPTH*AW-1:0] stg_rd,
  output logic                hit
);

  logic [DEPTH-1:0] per_stage;
  logic             addr_live;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    always_comb per_stage[g] = stg_wr[g] && (stg_rd[g*AW +: AW] == addr);
  end

  always_comb begin
    addr_live = (addr != '0);
    hit       = used && addr_live && (|per_stage);
  end

endmodule

// File: rtl/hz_ctrl.sv
// Resolves hold against redirect; hold wins.
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               id_valid,
  input  logic [NUM_SRC-1:0] src_hit,
  input  logic               is_branch,
  input  logic               br_cond,
  output logic               stall,
  output logic               bubble,
  output logic               flush
);

  hz_action_e act;

  always_comb begin
    act = HZ_RUN;
    if (id_valid && (|src_hit)) begin
      act = HZ_HOLD;
    end else if (id_valid && is_branch && br_cond) begin
      act = HZ_REDIRECT;
    end
  end

  always_comb begin
    stall  = (act == HZ_HOLD);
    bubble = (act == HZ_HOLD);
    flush  = (act == HZ_REDIRECT);
  end

endmodule

// File: rtl/hz_interlock.sv
// Decode-stage interlock for a pipeline without operand bypass.
module hz_interlock #(
  parameter int REG_AW      = 5,
  parameter int NUM_SRC     = 2,
  // Stages between decode and write-back whose results are not yet readable.
  parameter int HOLD_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      id_valid_i,
  input  logic [NUM_SRC*REG_AW-1:0] id_src_addr_i,
  input  logic [NUM_SRC-1:0]        id_src_used_i,
  input  logic [REG_AW-1:0]         id_dst_addr_i,
  input  logic                      id_dst_we_i,
  input  logic                      id_is_branch_i,
  input  logic                      id_br_cond_i,
  output logic                      stall_o,
  output logic                      bubble_o,
  output logic                      flush_o
);

  localparam int TRK_W = HOLD_STAGES * REG_AW;

  logic [HOLD_STAGES-1:0] trk_wr;
  logic [TRK_W-1:0]       trk_rd;
  logic [NUM_SRC-1:0]     src_hit;
  logic                   push_wr;
  logic                   stall_w;
  logic                   bubble_w;
  logic                   flush_w;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    hz_src_match #(
      .AW    (REG_AW),
      .DEPTH (HOLD_STAGES)
    ) match_i (
      .used   (id_src_used_i[k]),
      .addr   (id_src_addr_i[k*REG_AW +: REG_AW]),
      .stg_wr (trk_wr),
      .stg_rd (trk_rd),
      .hit    (src_hit[k])
    );
  end

  hz_ctrl #(
    .NUM_SRC (NUM_SRC)
  ) ctrl_i (
    .id_valid  (id_valid_i),
    .src_hit   (src_hit),
    .is_branch (id_is_branch_i),
    .br_cond   (id_br_cond_i),
    .stall     (stall_w),
    .bubble    (bubble_w),
    .flush     (flush_w)
  );

  // A record enters execute only for an accepted, writing, nonzero destination;
  // a stall cycle pushes an empty record (the bubble).
  always_comb begin
    push_wr = id_valid_i && id_dst_we_i && (id_dst_addr_i != '0) && !stall_w;
  end

  hz_dst_track #(
    .AW    (REG_AW),
    .DEPTH (HOLD_STAGES)
  ) track_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_wr  (push_wr),
    .in_rd  (id_dst_addr_i),
    .stg_wr (trk_wr),
    .stg_rd (trk_rd)
  );

  always_comb begin
    stall_o  = stall_w;
    bubble_o = bubble_w;
    flush_o  = flush_w;
  end

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      id_valid_i,
  input logic [NUM_SRC*REG_AW-1:0] id_src_addr_i,
  input logic [NUM_SRC-1:0]        id_src_used_i,
  input logic [REG_AW-1:0]         id_dst_addr_i,
  input logic                      id_dst_we_i,
  input logic                      id_is_branch_i,
  input logic                      id_br_cond_i,
  input logic                      stall_o,
  input logic                      bubble_o,
  input logic                      flush_o
);

  logic [1:0]        cyc_q;
  logic              p1_wr, p2_wr;
  logic [REG_AW-1:0] p1_rd, p2_rd;
  logic              acc_wr;
  logic              dep1, dep2, zero_only;

  always_comb acc_wr = id_valid_i && id_dst_we_i && (id_dst_addr_i != '0) && !stall_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      p1_wr <= 1'b0;
      p2_wr <= 1'b0;
      p1_rd <= '0;
      p2_rd <= '0;
    end else begin
      if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
      p1_wr <= acc_wr;
      p1_rd <= id_dst_addr_i;
      p2_wr <= p1_wr;
      p2_rd <= p1_rd;
    end
  end

  always_comb begin
    dep1      = 1'b0;
    dep2      = 1'b0;
    zero_only = 1'b1;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (id_src_used_i[k] && id_src_addr_i[k*REG_AW +: REG_AW] != '0) begin
        zero_only = 1'b0;
        if (id_src_addr_i[k*REG_AW +: REG_AW] == p1_rd) dep1 = 1'b1;
        if (id_src_addr_i[k*REG_AW +: REG_AW] == p2_rd) dep2 = 1'b1;
      end
    end
  end

  assert_fresh_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd0) |-> !stall_o);

  assert_ex_producer_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd1 && p1_wr && id_valid_i && dep1) |-> stall_o);

  assert_mem_producer_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && p2_wr && id_valid_i && dep2) |-> stall_o);

  assert_zero_reg_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_only |-> !stall_o);

  assert_bubble_tracks_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o == stall_o);

  assert_taken_flushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid_i && id_is_branch_i && id_br_cond_i && !stall_o) |-> flush_o);

  assert_hold_beats_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !flush_o);

  assert_empty_slot_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_i |-> (!stall_o && !flush_o));

endmodule

bind hz_interlock hz_interlock_chk #(
  .REG_AW  (REG_AW),
  .NUM_SRC (NUM_SRC)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .id_valid_i     (id_valid_i),
  .id_src_addr_i  (id_src_addr_i),
  .id_src_used_i  (id_src_used_i),
  .id_dst_addr_i  (id_dst_addr_i),
  .id_dst_we_i    (id_dst_we_i),
  .id_is_branch_i (id_is_branch_i),
  .id_br_cond_i   (id_br_cond_i),
  .stall_o        (stall_o),
  .bubble_o       (bubble_o),
  .flush_o        (flush_o)
);

// File: tb/hz_interlock_tb_top.sv
`timescale 1ns/1ps
module hz_interlock_tb_top;

  logic        clk;
  logic        rst_n;
  logic        id_valid_i;
  logic [9:0]  id_src_addr_i;
  logic [1:0]  id_src_used_i;
  logic [4:0]  id_dst_addr_i;
  logic        id_dst_we_i;
  logic        id_is_branch_i;
  logic        id_br_cond_i;
  logic        stall_o, bubble_o, flush_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Reference: destinations (or -1) of the two instructions ahead of decode.
  int exq[$];
  int bubbles_seen;
  bit last_stall, last_flush;

  hz_interlock dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .id_valid_i     (id_valid_i),
    .id_src_addr_i  (id_src_addr_i),
    .id_src_used_i  (id_src_used_i),
    .id_dst_addr_i  (id_dst_addr_i),
    .id_dst_we_i    (id_dst_we_i),
    .id_is_branch_i (id_is_branch_i),
    .id_br_cond_i   (id_br_cond_i),
    .stall_o        (stall_o),
    .bubble_o       (bubble_o),
    .flush_o        (flush_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drives one decode cycle, compares at the falling edge, advances the model.
  task automatic step(input bit v, input int s0, input bit u0, input int s1, input bit u1,
                      input int d, input bit we, input bit br, input bit cond, input string req);
    bit exp_stall, exp_flush;
    id_valid_i     = v;
    id_src_addr_i  = {s1[4:0], s0[4:0]};
    id_src_used_i  = {u1, u0};
    id_dst_addr_i  = d[4:0];
    id_dst_we_i    = we;
    id_is_branch_i = br;
    id_br_cond_i   = cond;
    exp_stall = 0;
    foreach (exq[i]) begin
      if (v && u0 && s0 != 0 && exq[i] == s0) exp_stall = 1;
      if (v && u1 && s1 != 0 && exq[i] == s1) exp_stall = 1;
    end
    exp_flush = v && br && cond && !exp_stall;
    @(negedge clk);
    check(stall_o == exp_stall, req, "stall", stall_o, exp_stall);
    check(bubble_o == exp_stall, "R7", "bubble", bubble_o, exp_stall);
    check(flush_o == exp_flush, (br ? "R9" : "R8"), "flush", flush_o, exp_flush);
    if (bubble_o) bubbles_seen++;
    last_stall = exp_stall;
    last_flush = exp_flush;
    @(posedge clk);
    exq.push_front((v && we && d != 0 && !exp_stall) ? d : -1);
    void'(exq.pop_back());
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  // Test program: s0,u0,s1,u1,dst,we,branch. Branch at index 3 targets index 7.
  task automatic get_instr(input int pc, output int f[7]);
    case (pc)
      0: f = '{4, 1, 0, 0, 1, 1, 0};  // load r1 <- [r4]
      1: f = '{5, 1, 0, 0, 2, 1, 0};  // load r2 <- [r5]
      2: f = '{1, 1, 2, 1, 3, 1, 0};  // add r3 = r1 + r2
      3: f = '{3, 1, 0, 0, 0, 0, 1};  // branch on r3
      4: f = '{1, 1, 0, 0, 4, 1, 0};  // load r4 <- [r1]
      5: f = '{2, 1, 0, 0, 5, 1, 0};  // load r5 <- [r2]
      6: f = '{4, 1, 5, 1, 3, 1, 0};  // sub r3 = r4 - r5
      default: f = '{1, 1, 3, 1, 0, 0, 0};  // store [r1] <- r3
    endcase
  endtask

  task automatic run_prog(input bit taken, input int exp_cyc, input int exp_bub);
    int pc, cyc, b0;
    bit empty_slot;
    int f[7];
    pc = 0; cyc = 0; empty_slot = 0; b0 = bubbles_seen;
    while (pc < 8 && cyc < 100) begin
      cyc++;
      if (empty_slot) begin
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        empty_slot = 0;
      end else begin
        get_instr(pc, f);
        step(1, f[0], f[1][0], f[2], f[3][0], f[4], f[5][0], f[6][0], taken, "R11");
        if (!last_stall) begin
          if (last_flush) begin pc = 7; empty_slot = 1; end
          else pc++;
        end
      end
    end
    check(cyc == exp_cyc, "R11", taken ? "taken cycles" : "fallthrough cycles", cyc, exp_cyc);
    check(bubbles_seen - b0 == exp_bub, "R11", "bubble total", bubbles_seen - b0, exp_bub);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exq = '{-1, -1};
    bubbles_seen = 0;
    rst_n = 1'b0;
    id_valid_i = 0; id_src_addr_i = '0; id_src_used_i = '0; id_dst_addr_i = '0;
    id_dst_we_i = 0; id_is_branch_i = 0; id_br_cond_i = 0;
    repeat (3) @(posedge clk);
    // R1: in reset, a reader of r1 and r2 sees nothing outstanding.
    id_valid_i = 1; id_src_addr_i = {5'd2, 5'd1}; id_src_used_i = 2'b11;
    @(negedge clk);
    check(stall_o == 0, "R1", "stall in reset", stall_o, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    step(1, 1, 1, 2, 1, 6, 1, 0, 0, "R1");  // first instruction after reset
    idle(2);

    run_prog(0, 16, 8);                     // R11 fall-through
    idle(2);
    run_prog(1, 10, 4);                     // R11 taken
    idle(2);

    // R2 and R3: consumer directly behind a producer holds two cycles.
    step(1, 7, 1, 0, 0, 14, 1, 0, 0, "R2");
    step(1, 14, 1, 0, 0, 15, 1, 0, 0, "R2");
    check(last_stall == 1, "R2", "ex dependency held", last_stall, 1);
    step(1, 14, 1, 0, 0, 15, 1, 0, 0, "R3");
    check(last_stall == 1, "R3", "mem dependency held", last_stall, 1);
    step(1, 14, 1, 0, 0, 15, 1, 0, 0, "R3");
    check(last_stall == 0, "R3", "released at write-back", last_stall, 0);
    // R7: bubbles carry no write; reader of r14 now passes.
    step(1, 14, 1, 0, 0, 0, 0, 0, 0, "R7");
    idle(2);

    // R4: producer three ahead never stalls.
    step(1, 0, 0, 0, 0, 12, 1, 0, 0, "R4");
    step(1, 0, 0, 0, 0, 20, 1, 0, 0, "R4");
    step(1, 0, 0, 0, 0, 21, 1, 0, 0, "R4");
    step(1, 12, 1, 0, 0, 0, 0, 0, 0, "R4");
    check(last_stall == 0, "R4", "write-back producer", last_stall, 0);
    idle(2);

    // R5: writing and reading r0.
    step(1, 0, 0, 0, 0, 0, 1, 0, 0, "R5");
    step(1, 0, 1, 0, 1, 9, 1, 0, 0, "R5");
    check(last_stall == 0, "R5", "r0 reader", last_stall, 0);
    idle(2);

    // R6: store whose data register (second field) is the fresh result.
    step(1, 0, 0, 0, 0, 9, 1, 0, 0, "R6");
    step(1, 1, 1, 9, 1, 0, 0, 0, 0, "R6");
    check(last_stall == 1, "R6", "store data dependency", last_stall, 1);
    step(1, 1, 1, 9, 1, 0, 0, 0, 0, "R6");
    step(1, 1, 1, 9, 1, 0, 0, 0, 0, "R6");
    idle(2);

    // R10: empty slot and unused field matching a fresh producer.
    step(1, 0, 0, 0, 0, 10, 1, 0, 0, "R10");
    step(0, 10, 1, 10, 1, 0, 0, 1, 1, "R10");
    check(last_stall == 0 && last_flush == 0, "R10", "empty slot quiet", last_stall, 0);
    step(1, 10, 0, 10, 0, 0, 0, 0, 0, "R10");
    check(last_stall == 0, "R10", "unused source", last_stall, 0);
    idle(2);

    // R9 then R8: taken branch waits for its operand, then flushes once.
    step(1, 0, 0, 0, 0, 11, 1, 0, 0, "R9");
    step(1, 11, 1, 0, 0, 0, 0, 1, 1, "R9");
    check(last_stall == 1 && last_flush == 0, "R9", "no redirect while held", flush_o, 0);
    step(1, 11, 1, 0, 0, 0, 0, 1, 1, "R9");
    step(1, 11, 1, 0, 0, 0, 0, 1, 1, "R8");
    check(last_flush == 1, "R8", "flush on release", last_flush, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    check(last_flush == 0, "R8", "flush lasts one cycle", last_flush, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule